// File: doc/BRIEF.md
# Steered Replicated Register Bank

This block holds one logical register that exists in several physical copies, one per hardware unit. The units are arranged as a number of groups, each holding a number of instances. All copies answer at one shared data offset. A separate selector register chooses which copy a unicast operation touches; this choice is called steering. The selector also carries a mode bit. In multicast mode a write to the data offset goes to every copy. In unicast mode the write goes only to the steered copy.

Reads of the data offset are always unicast and return the steered copy, whatever the mode bit says. Each copy has an enable input. The enable is low when the unit is fused off or power-gated. An access steered to a disabled copy, or to a group or instance index that does not exist, is terminated. A terminated read returns zero. A terminated write is dropped and no error is raised. A multicast write leaves the disabled copies unchanged.

The bus port takes one request per cycle. Its ready output is always high. Read data comes back one cycle after the read is accepted.

Top module: `steer_regbank`

## Requirements
- R1: After reset the selector reads back as zero, which means group 0, instance 0 and unicast mode. Every copy holds zero.
- R2: A write to the selector offset (byte address 0x0) stores three fields. Bit 0 is the mode (1 = multicast). Bits 15:8 are the group index. Bits 23:16 are the instance index. A read of the selector returns these fields, and every other bit reads as zero.
- R3: In unicast mode, a write to the data offset (byte address 0x4) changes only the steered copy. The steered copy is the one at flat index group*NINST + instance.
- R4: In multicast mode, a write to the data offset stores the same value in every enabled copy.
- R5: A read of the data offset returns the steered copy in both modes.
- R6: A copy whose enable is low is never changed by any write, whether unicast or multicast.
- R7: A read of the data offset steered to a copy whose enable is low returns zero.
- R8: A group index of NGRP or more, or an instance index of NINST or more, is terminated. Reads of the data offset return zero. Unicast writes change nothing.
- R9: The request ready output is always high. The read-valid output is high exactly in the cycle after an accepted read, and low at all other times.
- R10: A read of any offset other than the selector or the data offset returns zero. A write to such an offset changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address of the request |
| req_wdata | input | DW | Write data |
| unit_en | input | NGRP*NINST | Per-copy enable, bit index group*NINST + instance |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DW | Registered read data |

## Verification
The bench builds the block with NGRP=2 and NINST=3. This gives six copies, and because three is not a power of two, the instance field can name a slot (index 3) that does not exist. That brings the out-of-range termination rule within reach next to the fused-off case. For each of several enable masks, including all-on and all-off, the bench steers a unicast write to every group and instance value, including the missing slot. It then issues a multicast write and reads back every slot in both modes. Each read is compared against a six-entry model that the bench updates from the enable mask and the mode.

// File: rtl/steer_pkg.sv
package steer_pkg;
   // Field positions of the selector register
   localparam int SEL_MODE_BIT = 0;
   localparam int SEL_GRP_LSB  = 8;
   localparam int SEL_INST_LSB = 16;
   localparam int SEL_FLD_W    = 8;
   localparam int SEL_USED_W   = SEL_INST_LSB + SEL_FLD_W;

   typedef struct packed {
      logic [SEL_FLD_W-1:0] inst;
      logic [SEL_FLD_W-1:0] grp;
      logic                 mcast;
   } steer_sel_t;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_SEL  = 2'd1,
      TGT_DATA = 2'd2
   } steer_tgt_t;
endpackage

// File: rtl/steer_decode.sv
module steer_decode
   import steer_pkg::*;
#(
   parameter int AW        = 8,
   parameter int SEL_ADDR  = 0,
   parameter int DATA_ADDR = 4
) (
   input  logic [AW-1:0] addr,
   output steer_tgt_t    tgt
);
   localparam logic [AW-1:0] SEL_A  = AW'(SEL_ADDR);
   localparam logic [AW-1:0] DATA_A = AW'(DATA_ADDR);

   if (SEL_ADDR == DATA_ADDR) begin : g_bad_map
      $error("steer_decode: selector and data offsets collide");
   end

   always_comb begin
      if (addr == SEL_A)       tgt = TGT_SEL;
      else if (addr == DATA_A) tgt = TGT_DATA;
      else                     tgt = TGT_NONE;
   end
endmodule

// File: rtl/steer_select.sv
module steer_select
   import steer_pkg::*;
#(
   parameter int NGRP  = 4,
   parameter int NINST = 4,
   parameter int NCOPY = NGRP * NINST,
   parameter int IDXW  = (NCOPY > 1) ? $clog2(NCOPY) : 1
) (
   input  steer_sel_t       sel,
   input  logic [NCOPY-1:0] unit_en,
   input  logic             wr_data,
   output logic [IDXW-1:0]  idx,
   output logic             live,
   output logic [NCOPY-1:0] we_mask
);
   logic in_rng;
   int   flat;

   always_comb begin
      in_rng = (int'(sel.grp) < NGRP) && (int'(sel.inst) < NINST);
      flat   = in_rng ? (int'(sel.grp) * NINST + int'(sel.inst)) : 0;
      idx    = IDXW'(flat);
      live   = in_rng && unit_en[flat];
   end

   // Per-copy write enable: multicast reaches every live unit,
   // unicast only the steered live unit.
   for (genvar k = 0; k < NCOPY; k++) begin : g_we
      if (NCOPY == 1) begin : g_single
         assign we_mask[k] = wr_data && unit_en[k] && (sel.mcast || live);
      end else begin : g_multi
         assign we_mask[k] = wr_data && unit_en[k] &&
                             (sel.mcast || (live && (idx == IDXW'(k))));
      end
   end
endmodule

// File: rtl/steer_store.sv
module steer_store #(
   parameter int NCOPY = 16,
   parameter int DW    = 32,
   parameter int IDXW  = (NCOPY > 1) ? $clog2(NCOPY) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NCOPY-1:0]    we_mask,
   input  logic [DW-1:0]       wdata,
   input  logic [IDXW-1:0]     rd_idx,
   output logic [NCOPY*DW-1:0] bank_flat,
   output logic [DW-1:0]       rd_word
);
   logic [DW-1:0] cells [NCOPY];

   for (genvar k = 0; k < NCOPY; k++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          cells[k] <= '0;
         else if (we_mask[k]) cells[k] <= wdata;
      end
      assign bank_flat[k*DW +: DW] = cells[k];
   end

   always_comb begin
      rd_word = '0;
      for (int k = 0; k < NCOPY; k++) begin
         if (rd_idx == IDXW'(k)) rd_word = cells[k];
      end
   end
endmodule

// File: rtl/steer_regbank.sv
module steer_regbank
   import steer_pkg::*;
#(
   parameter int NGRP      = 4,
   parameter int NINST     = 4,
   parameter int DW        = 32,
   parameter int AW        = 8,
   parameter int SEL_ADDR  = 0,
   parameter int DATA_ADDR = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic                  req_write,
   input  logic [AW-1:0]         req_addr,
   input  logic [DW-1:0]         req_wdata,
   input  logic [NGRP*NINST-1:0] unit_en,
   output logic                  rd_valid,
   output logic [DW-1:0]         rd_data
);
   localparam int NCOPY = NGRP * NINST;
   localparam int IDXW  = (NCOPY > 1) ? $clog2(NCOPY) : 1;

   if (NGRP < 1 || NGRP > (1 << SEL_FLD_W)) begin : g_bad_grp
      $error("steer_regbank: NGRP out of field range");
   end
   if (NINST < 1 || NINST > (1 << SEL_FLD_W)) begin : g_bad_inst
      $error("steer_regbank: NINST out of field range");
   end
   if (DW < SEL_USED_W) begin : g_bad_dw
      $error("steer_regbank: DW too narrow for selector fields");
   end

   steer_tgt_t          tgt;
   steer_sel_t          sel_q;
   logic [23:0]         sel_word;
   logic [DW-1:0]       sel_rd;
   logic                acc_wr, acc_rd;
   logic [IDXW-1:0]     idx;
   logic                live;
   logic [NCOPY-1:0]    we_mask;
   logic [NCOPY*DW-1:0] bank_flat;
   logic [DW-1:0]       rd_word;

   assign req_ready = 1'b1;
   assign acc_wr    = req_valid && req_write;
   assign acc_rd    = req_valid && !req_write;

   steer_decode #(.AW(AW), .SEL_ADDR(SEL_ADDR), .DATA_ADDR(DATA_ADDR)) u_dec (
      .addr (req_addr),
      .tgt  (tgt)
   );

   // Selector register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
      end else if (acc_wr && tgt == TGT_SEL) begin
         sel_q.mcast <= req_wdata[SEL_MODE_BIT];
         sel_q.grp   <= req_wdata[SEL_GRP_LSB +: SEL_FLD_W];
         sel_q.inst  <= req_wdata[SEL_INST_LSB +: SEL_FLD_W];
      end
   end

   assign sel_word = {sel_q.inst, sel_q.grp, 7'b0, sel_q.mcast};
   assign sel_rd   = DW'(sel_word);

   steer_select #(.NGRP(NGRP), .NINST(NINST), .NCOPY(NCOPY), .IDXW(IDXW)) u_sel (
      .sel     (sel_q),
      .unit_en (unit_en),
      .wr_data (acc_wr && tgt == TGT_DATA),
      .idx     (idx),
      .live    (live),
      .we_mask (we_mask)
   );

   steer_store #(.NCOPY(NCOPY), .DW(DW), .IDXW(IDXW)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_mask   (we_mask),
      .wdata     (req_wdata),
      .rd_idx    (idx),
      .bank_flat (bank_flat),
      .rd_word   (rd_word)
   );

   // Registered read port, one cycle of latency
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= acc_rd;
         if (acc_rd) begin
            unique case (tgt)
               TGT_SEL:  rd_data <= sel_rd;
               TGT_DATA: rd_data <= live ? rd_word : '0;
               default:  rd_data <= '0;
            endcase
         end
      end
   end
endmodule

// File: rtl/steer_regbank_chk.sv
module steer_regbank_chk #(
   parameter int NGRP      = 4,
   parameter int NINST     = 4,
   parameter int DW        = 32,
   parameter int AW        = 8,
   parameter int DATA_ADDR = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     req_valid,
   input logic                     req_write,
   input logic [AW-1:0]            req_addr,
   input logic [NGRP*NINST-1:0]    unit_en,
   input logic                     rd_valid,
   input logic [DW-1:0]            rd_data,
   input logic [NGRP*NINST*DW-1:0] bank_flat,
   input logic [23:0]              sel_word
);
   localparam int NCOPY = NGRP * NINST;

   logic [NCOPY*DW-1:0] prev_q;
   logic [NCOPY-1:0]    chg;
   logic                live_c;
   logic                data_acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= bank_flat;
   end

   for (genvar k = 0; k < NCOPY; k++) begin : g_chg
      assign chg[k] = bank_flat[k*DW +: DW] != prev_q[k*DW +: DW];
   end

   always_comb begin
      int g, i;
      g = int'(sel_word[15:8]);
      i = int'(sel_word[23:16]);
      live_c = (g < NGRP) && (i < NINST) && unit_en[(g < NGRP && i < NINST) ? g*NINST+i : 0];
   end

   assign data_acc = req_valid && (req_addr == AW'(DATA_ADDR));

   a_r9_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rd_valid);

   a_r9_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !req_write) |=> !rd_valid);

   a_r7_r8_term_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (data_acc && !req_write && !live_c) |=> (rd_data == '0));

   a_r3_unicast_one_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (data_acc && req_write && !sel_word[0]) |=> ($countones(chg) <= 1));

   a_r10_no_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      !(data_acc && req_write) |=> (chg == '0));

   a_r6_disabled_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_en != {NCOPY{1'b1}}) |=> ((chg & ~$past(unit_en)) == '0));
endmodule

bind steer_regbank steer_regbank_chk #(
   .NGRP(NGRP), .NINST(NINST), .DW(DW), .AW(AW), .DATA_ADDR(DATA_ADDR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_addr  (req_addr),
   .unit_en   (unit_en),
   .rd_valid  (rd_valid),
   .rd_data   (rd_data),
   .bank_flat (bank_flat),
   .sel_word  (sel_word)
);

// File: tb/sim_steer_regbank.sv
module sim_steer_regbank;
   localparam int NG = 2;
   localparam int NI = 3;
   localparam int NC = NG * NI;
   localparam logic [7:0] A_SEL  = 8'h00;
   localparam logic [7:0] A_DATA = 8'h04;
   localparam logic [7:0] A_OTH  = 8'h08;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [7:0]    req_addr = '0;
   logic [31:0]   req_wdata = '0;
   logic [NC-1:0] unit_en = '1;
   logic          rd_valid;
   logic [31:0]   rd_data;

   int checks = 0;
   int errors = 0;
   logic [31:0] mdl [NC];

   always #10 clk = ~clk;

   steer_regbank #(.NGRP(NG), .NINST(NI), .DW(32), .AW(8), .SEL_ADDR(0), .DATA_ADDR(4)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .unit_en(unit_en), .rd_valid(rd_valid), .rd_data(rd_data)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      chk("R9 no valid after write", {31'b0, rd_valid}, 32'd0);
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9 read valid", {31'b0, rd_valid}, 32'd1);
      d = rd_data;
   endtask

   function automatic logic [31:0] selv(input int mc, input int g, input int i);
      return {8'h00, 8'(i), 8'(g), 7'b0, 1'(mc)};
   endfunction

   function automatic logic [31:0] expect_rd(input int g, input int i);
      if (g < NG && i < NI && unit_en[g*NI+i]) return mdl[g*NI+i];
      return 32'd0;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [NC-1:0] masks [5];
      masks[0] = 6'b111111; masks[1] = 6'b101101; masks[2] = 6'b010010;
      masks[3] = 6'b000000; masks[4] = 6'b110011;
      for (int k = 0; k < NC; k++) mdl[k] = '0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 ready high", {31'b0, req_ready}, 32'd1);
      chk("R1 rd_valid idle", {31'b0, rd_valid}, 32'd0);
      // R1: reset state of selector and all copies
      rd(A_SEL, d);
      chk("R1 selector reset", d, 32'd0);
      for (int g = 0; g < NG; g++)
         for (int i = 0; i < NI; i++) begin
            wr(A_SEL, selv(0, g, i));
            rd(A_DATA, d);
            chk("R1 copy reset", d, 32'd0);
         end

      // R2: selector fields read back, unused bits zero
      wr(A_SEL, 32'hFF5A_A3F1);
      rd(A_SEL, d);
      chk("R2 selector readback", d, 32'h005A_A301);

      for (int m = 0; m < 5; m++) begin
         @(negedge clk);
         unit_en = masks[m];
         // R3 R6 R8: unicast writes to every slot including instance 3
         for (int g = 0; g < NG; g++)
            for (int i = 0; i <= NI; i++) begin
               logic [31:0] v;
               v = 32'hC000_0000 | (m << 16) | (g << 8) | i;
               wr(A_SEL, selv(0, g, i));
               wr(A_DATA, v);
               if (i < NI && unit_en[g*NI+i]) mdl[g*NI+i] = v;
               // R3: other copies untouched, checked by full readback below
            end
         for (int g = 0; g < NG; g++)
            for (int i = 0; i <= NI; i++) begin
               wr(A_SEL, selv(0, g, i));
               rd(A_DATA, d);
               chk("R3 R6 R7 R8 unicast readback", d, expect_rd(g, i));
            end
         // R4: multicast write, steered at an arbitrary (even dead) slot
         wr(A_SEL, selv(1, 1, 3));
         wr(A_DATA, 32'h5500_0000 | m);
         for (int k = 0; k < NC; k++)
            if (unit_en[k]) mdl[k] = 32'h5500_0000 | m;
         // R5: read back in multicast and in unicast mode
         for (int mc = 0; mc < 2; mc++)
            for (int g = 0; g < NG; g++)
               for (int i = 0; i <= NI; i++) begin
                  wr(A_SEL, selv(mc, g, i));
                  rd(A_DATA, d);
                  chk("R4 R5 R7 R8 multicast readback", d, expect_rd(g, i));
               end
      end

      // R10: other offsets
      @(negedge clk);
      unit_en = '1;
      wr(A_SEL, selv(0, 0, 0));
      wr(A_OTH, 32'hDEAD_BEEF);
      rd(A_OTH, d);
      chk("R10 other offset reads zero", d, 32'd0);
      rd(A_DATA, d);
      chk("R10 data unchanged", d, mdl[0]);
      rd(A_SEL, d);
      chk("R10 selector unchanged", d, 32'd0);
      @(negedge clk);
      chk("R9 valid drops", {31'b0, rd_valid}, 32'd0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule